// File: doc/BRIEF.md
# Two-Level Direct Route Lookup

This block finds the next hop for an IPv4 destination address by longest-prefix match, using two directly indexed tables rather than walking a trie. The most significant address bits pick an entry in a flat first-level table. That entry either already holds the answer, for a route whose prefix fits within the first-level width, or points at a block in a second-level table. In the second case the next few address bits select an entry inside that block. Every lookup therefore costs at most two table reads, whatever the prefix length.

The engine is pipelined. It accepts one lookup per cycle on a valid/ready request and returns each result two cycles later, in request order. A single write port loads either table. Software expands prefixes into table contents before loading them. The split widths, the pointer width and the next-hop width are parameters, so a reduced table can stand in for the full 24/8 split. Next hop value 0 is reserved to mean "no route".

Top module: `route_lookup2`

## Requirements
- R1: While `rst_n` is low, `res_valid` is 0 and `req_ready` is 0. From the second rising edge after reset is released, `req_ready` stays 1.
- R2: The first-level index is `req_addr[31 -: L1_BITS]`. When the selected entry has its flag bit (bit NH_W) at 0, the result next hop is the entry's low NH_W bits.
- R3: When the flag bit (bit NH_W) of the first-level entry is 1, the entry's low PTR_W bits are a block number in the second-level table, and the result next hop is the second-level entry that is read.
- R4: The second-level index is block × 2^L2_BITS + `req_addr[31-L1_BITS -: L2_BITS]`. A second-level read only happens in the cycle after a first-level read.
- R5: Address bits below the top L1_BITS+L2_BITS do not affect the result.
- R6: A request accepted at one rising edge gives `res_valid`=1 after the second rising edge that follows. Back-to-back requests give one result per cycle, in acceptance order.
- R7: A lookup that ends on an all-zero first-level entry, or on a second-level entry of 0, returns `res_hit`=0 and `res_nh`=0. Any nonzero next hop returns `res_hit`=1.
- R8: A table write in the same cycle as an accepted lookup is not seen by that lookup, at either level. Lookups accepted in later cycles see it.
- R9: When `wr_en`=1, `wr_sel`=0 writes `wr_data` into first-level entry `wr_addr[L1_BITS-1:0]`. `wr_sel`=1 writes `wr_data[NH_W-1:0]` into second-level entry `wr_addr[PTR_W+L2_BITS-1:0]` and leaves the first table unchanged.
- R10: `res_hit` is 1 only when `res_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine accepts a request this cycle |
| req_addr | input | 32 | Destination address to resolve |
| res_valid | output | 1 | Result present this cycle |
| res_hit | output | 1 | A route was found |
| res_nh | output | NH_W | Next hop (0 when no route) |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | 0 = first-level table, 1 = second-level table |
| wr_addr | input | max(L1_BITS, PTR_W+L2_BITS) | Entry index to write |
| wr_data | input | NH_W+1 | Entry value: flag bit on top, payload below |

## Verification
The bench builds the block with a 12-bit first level, 4-bit blocks, 16 second-level blocks and 8-bit next hops. That gives 4096 + 256 entries, so the bench can clear every entry and still reach both ends of both tables, including block 15 at offset 15. These reduced widths leave 16 ignored address bits, enough to show that the low address bits have no effect. The scoreboard keeps its own copy of both tables. It uses that copy to cover same-cycle write/lookup collisions at each level and long bursts that mix direct hits, pointer hits and misses.

// File: rtl/rl_pkg.sv
package rl_pkg;
  // Extract a w-bit field starting at bit lsb (w < 32).
  function automatic logic [31:0] addr_field(input logic [31:0] a,
                                             input int unsigned lsb,
                                             input int unsigned w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (a >> lsb) & mask;
  endfunction

  // Second-level index: block number scaled by block size, plus offset.
  function automatic logic [31:0] block_index(input logic [31:0] blk,
                                              input logic [31:0] off,
                                              input int unsigned m);
    return (blk << m) | off;
  endfunction
endpackage

// File: rtl/rl_table.sv
module rl_table #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Read returns the contents from before a write in the same cycle.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rl_decode.sv
module rl_decode
  import rl_pkg::*;
#(
  parameter int unsigned NH_W    = 8,
  parameter int unsigned PTR_W   = 4,
  parameter int unsigned L2_BITS = 4
) (
  input  logic [NH_W:0]              entry,
  input  logic [L2_BITS-1:0]         off,
  output logic                       is_ptr,
  output logic [NH_W-1:0]            nh,
  output logic [PTR_W+L2_BITS-1:0]   l2_addr
);
  localparam int unsigned L2_AW = PTR_W + L2_BITS;

  assign is_ptr  = entry[NH_W];
  assign nh      = entry[NH_W-1:0];
  assign l2_addr = L2_AW'(block_index(32'(entry[PTR_W-1:0]), 32'(off), L2_BITS));
endmodule

// File: rtl/route_lookup2.sv
module route_lookup2
  import rl_pkg::*;
#(
  parameter int unsigned L1_BITS = 12,
  parameter int unsigned L2_BITS = 4,
  parameter int unsigned PTR_W   = 4,
  parameter int unsigned NH_W    = 8,
  localparam int unsigned L2_AW   = PTR_W + L2_BITS,
  localparam int unsigned WA_W    = (L1_BITS > L2_AW) ? L1_BITS : L2_AW,
  localparam int unsigned ENTRY_W = NH_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [31:0]        req_addr,
  output logic               res_valid,
  output logic               res_hit,
  output logic [NH_W-1:0]    res_nh,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [WA_W-1:0]    wr_addr,
  input  logic [ENTRY_W-1:0] wr_data
);
  localparam int unsigned L1_LSB = 32 - L1_BITS;
  localparam int unsigned L2_LSB = L1_LSB - L2_BITS;

  // Named events, observed by the bound checker
  logic l1_rd_fire, l2_rd_fire, l2_wr_fire;

  logic ready_q;
  logic [L1_BITS-1:0] l1_idx;
  logic [L2_BITS-1:0] off_in;
  logic [ENTRY_W-1:0] l1_q;
  logic [NH_W-1:0]    l2_q;

  // Stage 1 state
  logic               s1_valid;
  logic [L2_BITS-1:0] s1_off;
  // Stage 2 state
  logic               s2_valid, s2_ptr;
  logic [NH_W-1:0]    s2_nh;
  // Delayed second-level write
  logic               pend_we;
  logic [L2_AW-1:0]   pend_addr;
  logic [NH_W-1:0]    pend_data;

  logic               dec_ptr;
  logic [NH_W-1:0]    dec_nh;
  logic [L2_AW-1:0]   dec_l2_addr;
  logic               unused_addr_bits;

  assign req_ready  = ready_q;
  assign l1_rd_fire = req_valid & ready_q;
  assign l1_idx     = L1_BITS'(addr_field(req_addr, L1_LSB, L1_BITS));
  assign off_in     = L2_BITS'(addr_field(req_addr, L2_LSB, L2_BITS));
  assign l2_rd_fire = s1_valid & dec_ptr;
  assign l2_wr_fire = pend_we;
  assign unused_addr_bits = ^req_addr;

  rl_table #(.AW(L1_BITS), .DW(ENTRY_W)) i_l1 (
    .clk   (clk),
    .we    (wr_en & ~wr_sel),
    .waddr (wr_addr[L1_BITS-1:0]),
    .wdata (wr_data),
    .re    (l1_rd_fire),
    .raddr (l1_idx),
    .rdata (l1_q)
  );

  rl_decode #(.NH_W(NH_W), .PTR_W(PTR_W), .L2_BITS(L2_BITS)) i_dec (
    .entry   (l1_q),
    .off     (s1_off),
    .is_ptr  (dec_ptr),
    .nh      (dec_nh),
    .l2_addr (dec_l2_addr)
  );

  rl_table #(.AW(L2_AW), .DW(NH_W)) i_l2 (
    .clk   (clk),
    .we    (pend_we),
    .waddr (pend_addr),
    .wdata (pend_data),
    .re    (l2_rd_fire),
    .raddr (dec_l2_addr),
    .rdata (l2_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
      s2_ptr   <= 1'b0;
      pend_we  <= 1'b0;
    end else begin
      ready_q  <= 1'b1;
      s1_valid <= l1_rd_fire;
      s2_valid <= s1_valid;
      s2_ptr   <= l2_rd_fire;
      pend_we  <= wr_en & wr_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (l1_rd_fire) s1_off <= off_in;
    if (s1_valid)   s2_nh  <= dec_nh;
    pend_addr <= wr_addr[L2_AW-1:0];
    pend_data <= wr_data[NH_W-1:0];
  end

  assign res_valid = s2_valid;
  assign res_nh    = s2_valid ? (s2_ptr ? l2_q : s2_nh) : '0;
  assign res_hit   = s2_valid & (res_nh != '0);
endmodule

// File: rtl/rl_lookup_chk.sv
module rl_lookup_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic res_valid,
  input logic res_hit,
  input logic l1_rd_fire,
  input logic l2_rd_fire,
  input logic l2_wr_fire,
  input logic wr_en,
  input logic wr_sel
);
  // R6
  res_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(req_valid && req_ready, 2));

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> req_ready);

  // R10
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_hit);

  // R8
  l2_wr_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l2_wr_fire == $past(wr_en && wr_sel));

  // R4
  l2_after_l1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l2_rd_fire |-> $past(l1_rd_fire));
endmodule

bind route_lookup2 rl_lookup_chk i_chk (.*);

// File: tb/test_route_lookup2.sv
module test_route_lookup2;
  localparam int L1 = 12;
  localparam int L2 = 4;
  localparam int PW = 4;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        res_valid, res_hit;
  logic [7:0]  res_nh;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [8:0]  wr_data = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [8:0] ref_l1 [4096];
  logic [7:0] ref_l2 [256];
  logic [7:0] exp_nh [$];
  string      exp_tag [$];

  always #2 clk = ~clk;

  route_lookup2 #(.L1_BITS(L1), .L2_BITS(L2), .PTR_W(PW), .NH_W(NW)) i_route_lookup2 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .res_valid(res_valid), .res_hit(res_hit), .res_nh(res_nh),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [7:0] model_nh(input logic [31:0] a);
    logic [8:0] e;
    int blk, off;
    e = ref_l1[a[31:20]];
    if (e[8]) begin
      blk = int'(e[3:0]);
      off = int'(a[19:16]);
      return ref_l2[blk * 16 + off];
    end
    return e[7:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus: optional lookup plus optional write
  task automatic step(input logic lv, input logic [31:0] la, input logic we,
                      input logic ws, input logic [11:0] wa, input logic [8:0] wd,
                      input string tag);
    @(negedge clk);
    if (lv) begin
      exp_nh.push_back(model_nh(la));
      exp_tag.push_back(tag);
    end
    if (we) begin
      if (ws) ref_l2[wa[7:0]] = wd[7:0];
      else    ref_l1[wa] = wd;
    end
    req_valid = lv; req_addr = la;
    wr_en = we; wr_sel = ws; wr_addr = wa; wr_data = wd;
  endtask

  task automatic look(input logic [31:0] a, input string tag);
    step(1'b1, a, 1'b0, 1'b0, '0, '0, tag);
  endtask

  task automatic wr(input logic ws, input logic [11:0] wa, input logic [8:0] wd);
    step(1'b0, '0, 1'b1, ws, wa, wd, "");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, '0, '0, "");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Monitor: compare each result against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_nh.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R6 unexpected result nh=%h expected none", res_nh);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_nh.pop_front();
        t = exp_tag.pop_front();
        check({t, " nh"}, 32'(res_nh), 32'(e));
        check({t, " hit R7"}, 32'(res_hit), 32'(e != 8'd0));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < 4096; i++) ref_l1[i] = '0;
    for (int i = 0; i < 256; i++) ref_l2[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(res_valid), 0);
    check("R1 ready in reset", 32'(req_ready), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 ready after reset", 32'(req_ready), 1);
    check("R1 valid after reset", 32'(res_valid), 0);

    // Clear both tables
    for (int i = 0; i < 4096; i++) wr(1'b0, 12'(i), 9'h000);
    for (int i = 0; i < 256; i++) wr(1'b1, 12'(i), 9'h000);
    idle(2);

    look(32'h1234_5678, "R7 empty table");
    // R2 direct entries, R5 varying low bits
    wr(1'b0, 12'h0A1, 9'h035);
    wr(1'b0, 12'h000, 9'h0F1);
    wr(1'b0, 12'hFFF, 9'h0E2);
    look(32'h0A10_0000, "R2 direct");
    look(32'h0A1F_FFFF, "R5 low bits ignored");
    look(32'h0A1A_5A5A, "R5 low bits ignored");
    look(32'h0000_0001, "R2 index zero");
    look(32'hFFFF_FFFF, "R2 index max");
    // R3/R4 pointer entries
    wr(1'b0, 12'hC00, 9'h103);
    wr(1'b1, 12'h035, 9'h077);
    wr(1'b1, 12'h030, 9'h011);
    wr(1'b1, 12'h03F, 9'h022);
    look(32'hC005_1234, "R4 offset 5");
    look(32'hC000_0000, "R4 offset 0");
    look(32'hC00F_FFFF, "R4 offset 15");
    look(32'hC007_0000, "R7 zero second-level");
    wr(1'b0, 12'h7FF, 9'h10F);
    wr(1'b1, 12'h0FF, 9'h0AB);
    look(32'h7FFF_0000, "R3 block 15 offset 15");
    // R9: second-level write at a number shared with a first-level entry
    wr(1'b1, 12'h0A1, 9'h199);
    look(32'h0A14_0000, "R9 sel keeps first table");
    // R8 same-cycle collisions
    step(1'b1, 32'h1230_0000, 1'b1, 1'b0, 12'h123, 9'h044, "R8 first-level old");
    look(32'h1230_0000, "R8 first-level new");
    step(1'b1, 32'hC009_0000, 1'b1, 1'b1, 12'h039, 9'h05A, "R8 second-level old");
    look(32'hC009_0000, "R8 second-level new");
    idle(3);

    // R6 burst with mixed regions and interleaved writes
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[1:0])
        2'd0: a = {12'h0A1, lfsr[31:12]};
        2'd1: a = {12'hC00, lfsr[27:8]};
        2'd2: a = {12'h7FF, lfsr[23:4]};
        default: a = lfsr;
      endcase
      if (i % 7 == 3)
        step(1'b1, a, 1'b1, 1'b1, {8'h03, lfsr[7:4]}, {1'b0, lfsr[15:8]}, "R6 burst");
      else
        look(a, "R6 burst");
    end
    idle(4);
    check("R6 all results returned", exp_nh.size(), 0);
    finish_run();
  end
endmodule